// File: doc/BRIEF.md
# Per-Set LRU Victim Selector

This unit sits inside each set of a set-associative cache and chooses which line of the set a fill writes into. It keeps one age counter per line, log2 of the way count wide, that records how recently the line was used. When every line of the set holds valid data it names the line that has gone unused the longest. When some line is still empty it names the lowest-numbered empty line, and the ages play no part in that choice.

The cache controller sends one update pulse for each access once the access is complete. A miss can take many clock cycles, and the ages must not move during that time. On the update pulse the accessed line becomes the youngest. The accessed line is the lowest-numbered line that hit. If no line hit, it is the line the victim output names in that cycle, which is the line being filled. The victim outputs are combinational from the stored ages and the valid bits of the current cycle.

Top module: `lru_repl_ctrl`

## Requirements
- R1: Reset is synchronous and active high. It sets the age of line i to i. With every line valid after reset, the victim is therefore line WAYS-1.
- R2: `victim_oh` is one-hot and has bit `victim_idx` set. Line i maps to bit i.
- R3: The ages change only at a rising clock edge where `upd_en` is 1. In any other cycle the victim stays the same for unchanged `valid_vec`, whatever `hit_vec` carries.
- R4: If any bit of `valid_vec` is 0, the victim is the lowest-numbered line whose valid bit is 0.
- R5: If every line is valid, the victim is the line with the largest age. That line is the one least recently accessed.
- R6: On an update, the accessed line is the lowest-numbered set bit of `hit_vec`. If `hit_vec` is zero, the accessed line is the line the victim output names in that cycle.
- R7: On an update, the accessed line's age becomes 0. Every line whose age was below the accessed line's old age gains 1. All other ages stay the same, so the ages always remain a permutation of 0..WAYS-1.
- R8: With WAYS=1, no state is kept and the victim is always line 0.
- R9: The victim outputs follow `valid_vec` in the same cycle. An update first shows on the victim outputs in the cycle after its clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_en | input | 1 | One-cycle pulse for each completed access |
| hit_vec | input | WAYS | Per-line tag-match flags of the access |
| valid_vec | input | WAYS | Per-line valid bits of the set |
| victim_idx | output | max(1,log2 WAYS) | Encoded fill/evict line |
| victim_oh | output | WAYS | One-hot fill/evict line |

## Verification
The victim outputs are combinational, so each expected victim is due in the same cycle the inputs are applied. The bench drives inputs at the falling edge and compares one nanosecond later, before the rising edge that takes in that vector's update. The effect of an update is due one edge later, so the bench checks it with the next vector. A reset applied in the middle of the run is checked in the first cycle after its edge. A one-way instance is checked with the same timing.

// File: rtl/lru_repl_pkg.sv
package lru_repl_pkg;

    // Width of a line index; at least one bit so single-way sets stay legal.
    function automatic int unsigned idx_width(input int unsigned ways);
        return (ways > 1) ? $clog2(ways) : 1;
    endfunction

    // Where the line touched by an update comes from.
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_HIT  = 2'd1,
        ACC_FILL = 2'd2
    } acc_src_e;

endpackage

// File: rtl/lru_hit_encode.sv
module lru_hit_encode #(
    parameter int unsigned WAYS  = 4,
    parameter int unsigned IDX_W = 2
) (
    input  logic [WAYS-1:0]  hit_vec,
    output logic             any_hit,
    output logic [IDX_W-1:0] hit_idx
);
    // Lowest-numbered hitting line wins.
    always_comb begin
        any_hit = 1'b0;
        hit_idx = '0;
        for (int i = 0; i < int'(WAYS); i++) begin
            if (hit_vec[i] && !any_hit) begin
                any_hit = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/lru_victim_pick.sv
module lru_victim_pick #(
    parameter int unsigned WAYS  = 4,
    parameter int unsigned AGE_W = 2,
    parameter int unsigned IDX_W = 2
) (
    input  logic [WAYS-1:0][AGE_W-1:0] ages,
    input  logic [WAYS-1:0]            valid_vec,
    output logic [IDX_W-1:0]           victim_idx,
    output logic [WAYS-1:0]            victim_oh
);
    logic [IDX_W-1:0] oldest_idx;
    logic [AGE_W-1:0] oldest_age;
    logic [IDX_W-1:0] empty_idx;
    logic             has_empty;

    // Oldest line: strict compare keeps the lowest index on a tie.
    always_comb begin
        oldest_idx = '0;
        oldest_age = ages[0];
        for (int i = 1; i < int'(WAYS); i++) begin
            if (ages[i] > oldest_age) begin
                oldest_age = ages[i];
                oldest_idx = IDX_W'(i);
            end
        end
    end

    // First empty line, searched from line 0 upward.
    always_comb begin
        has_empty = 1'b0;
        empty_idx = '0;
        for (int i = 0; i < int'(WAYS); i++) begin
            if (!valid_vec[i] && !has_empty) begin
                has_empty = 1'b1;
                empty_idx = IDX_W'(i);
            end
        end
    end

    assign victim_idx = has_empty ? empty_idx : oldest_idx;

    always_comb begin
        victim_oh = '0;
        for (int i = 0; i < int'(WAYS); i++) begin
            victim_oh[i] = (victim_idx == IDX_W'(i));
        end
    end
endmodule

// File: rtl/lru_age_bank.sv
module lru_age_bank #(
    parameter int unsigned WAYS  = 4,
    parameter int unsigned AGE_W = 2,
    parameter int unsigned IDX_W = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       upd_en,
    input  logic [IDX_W-1:0]           acc_idx,
    output logic [WAYS-1:0][AGE_W-1:0] ages
);
    logic [AGE_W-1:0] acc_age;

    assign acc_age = ages[acc_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(WAYS); i++) begin
                ages[i] <= AGE_W'(i);
            end
        end else if (upd_en) begin
            for (int i = 0; i < int'(WAYS); i++) begin
                if (acc_idx == IDX_W'(i)) begin
                    ages[i] <= '0;
                end else if (ages[i] < acc_age) begin
                    ages[i] <= ages[i] + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/lru_repl_ctrl.sv
module lru_repl_ctrl #(
    parameter int unsigned WAYS = 4
) (
    input  logic                                     clk,
    input  logic                                     rst,
    input  logic                                     upd_en,
    input  logic [WAYS-1:0]                          hit_vec,
    input  logic [WAYS-1:0]                          valid_vec,
    output logic [lru_repl_pkg::idx_width(WAYS)-1:0] victim_idx,
    output logic [WAYS-1:0]                          victim_oh
);
    import lru_repl_pkg::*;

    localparam int unsigned IDX_W = idx_width(WAYS);
    localparam int unsigned AGE_W = IDX_W;

    logic [WAYS-1:0][AGE_W-1:0] age_q;

    generate
        if (WAYS == 1) begin : g_single
            logic unused_w1;
            assign unused_w1  = ^{clk, rst, upd_en, hit_vec, valid_vec};
            assign age_q      = '0;
            assign victim_idx = '0;
            assign victim_oh  = 1'b1;
        end else begin : g_multi
            logic             any_hit;
            logic [IDX_W-1:0] hit_idx;
            logic [IDX_W-1:0] acc_idx;
            acc_src_e         acc_src;

            lru_hit_encode #(.WAYS(WAYS), .IDX_W(IDX_W)) u_enc (
                .hit_vec (hit_vec),
                .any_hit (any_hit),
                .hit_idx (hit_idx)
            );

            lru_victim_pick #(.WAYS(WAYS), .AGE_W(AGE_W), .IDX_W(IDX_W)) u_pick (
                .ages       (age_q),
                .valid_vec  (valid_vec),
                .victim_idx (victim_idx),
                .victim_oh  (victim_oh)
            );

            always_comb begin
                if (!upd_en)      acc_src = ACC_NONE;
                else if (any_hit) acc_src = ACC_HIT;
                else              acc_src = ACC_FILL;
            end

            assign acc_idx = (acc_src == ACC_HIT) ? hit_idx : victim_idx;

            lru_age_bank #(.WAYS(WAYS), .AGE_W(AGE_W), .IDX_W(IDX_W)) u_bank (
                .clk     (clk),
                .rst     (rst),
                .upd_en  (acc_src != ACC_NONE),
                .acc_idx (acc_idx),
                .ages    (age_q)
            );
        end
    endgenerate
endmodule

// File: rtl/lru_repl_chk.sv
module lru_repl_chk #(
    parameter int unsigned WAYS  = 4,
    parameter int unsigned IDX_W = 2,
    parameter int unsigned AGE_W = 2
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       upd_en,
    input logic [WAYS-1:0]            hit_vec,
    input logic [WAYS-1:0]            valid_vec,
    input logic [IDX_W-1:0]           victim_idx,
    input logic [WAYS-1:0]            victim_oh,
    input logic [WAYS-1:0][AGE_W-1:0] age_q
);
    logic [(1<<AGE_W)-1:0] seen;
    logic [WAYS-1:0]       low_hit;

    always_comb begin
        seen = '0;
        for (int i = 0; i < int'(WAYS); i++) begin
            seen[age_q[i]] = 1'b1;
        end
    end

    assign low_hit = hit_vec & (~hit_vec + 1'b1);

    // R2
    p_oh_matches_idx_r2: assert property (@(posedge clk) disable iff (rst)
        victim_oh == (WAYS'(1) << victim_idx));

    // R3
    p_ages_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !upd_en |=> $stable(age_q));

    // R4
    p_empty_first_r4: assert property (@(posedge clk) disable iff (rst)
        (~valid_vec != '0) |-> !valid_vec[victim_idx]);

    // R7
    p_ages_permute_r7: assert property (@(posedge clk) disable iff (rst)
        $countones(seen) == WAYS);

    generate
        if (WAYS > 1) begin : g_multi_chk
            // R6
            p_recent_kept_r6: assert property (@(posedge clk) disable iff (rst)
                (upd_en && hit_vec != '0) |=>
                    (((victim_oh & $past(low_hit)) == '0) || (valid_vec != '1)));
        end else begin : g_single_chk
            // R8
            p_single_line_r8: assert property (@(posedge clk) disable iff (rst)
                victim_idx == '0);
        end
    endgenerate
endmodule

bind lru_repl_ctrl lru_repl_chk #(
    .WAYS  (WAYS),
    .IDX_W (IDX_W),
    .AGE_W (AGE_W)
) u_lru_chk (
    .clk        (clk),
    .rst        (rst),
    .upd_en     (upd_en),
    .hit_vec    (hit_vec),
    .valid_vec  (valid_vec),
    .victim_idx (victim_idx),
    .victim_oh  (victim_oh),
    .age_q      (age_q)
);

// File: tb/test_lru_repl_ctrl.sv
`timescale 1ns/1ps
module test_lru_repl_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       upd_en = 1'b0;
    logic [3:0] hit_vec = '0;
    logic [3:0] valid_vec = '0;
    logic [1:0] victim_idx;
    logic [3:0] victim_oh;

    logic       w1_upd = 1'b0;
    logic [0:0] w1_hit = '0;
    logic [0:0] w1_valid = '0;
    logic [0:0] w1_idx;
    logic [0:0] w1_oh;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    lru_repl_ctrl #(.WAYS(4)) i_lru_repl_ctrl (
        .clk(clk), .rst(rst), .upd_en(upd_en), .hit_vec(hit_vec),
        .valid_vec(valid_vec), .victim_idx(victim_idx), .victim_oh(victim_oh)
    );

    lru_repl_ctrl #(.WAYS(1)) i_lru_repl_ctrl_w1 (
        .clk(clk), .rst(rst), .upd_en(w1_upd), .hit_vec(w1_hit),
        .valid_vec(w1_valid), .victim_idx(w1_idx), .victim_oh(w1_oh)
    );

    // Vector fields: {upd, req tag, hit[3:0], valid[3:0], expected victim[1:0]}.
    // Model ages listed as [line0,line1,line2,line3]; reset gives [0,1,2,3].
    localparam int NV = 16;
    localparam logic [14:0] VEC [NV] = '{
        {1'b0, 4'd1, 4'h0, 4'hF, 2'd3}, // R1 reset order, victim 3
        {1'b1, 4'd7, 4'h1, 4'hF, 2'd3}, // R7 hit youngest: no change
        {1'b1, 4'd7, 4'h4, 4'hF, 2'd3}, // R7 hit line2 -> [1,2,0,3]
        {1'b1, 4'd5, 4'h8, 4'hF, 2'd3}, // R5 hit line3 -> [2,3,1,0]
        {1'b0, 4'd5, 4'h2, 4'hF, 2'd1}, // R5 oldest is line1
        {1'b0, 4'd3, 4'h0, 4'hF, 2'd1}, // R3 hit without enable ignored
        {1'b1, 4'd6, 4'h0, 4'hF, 2'd1}, // R6 fill line1 -> [3,0,2,1]
        {1'b0, 4'd6, 4'h0, 4'hF, 2'd0}, // R6 filled line now youngest
        {1'b0, 4'd4, 4'h0, 4'hB, 2'd2}, // R4 line2 empty
        {1'b0, 4'd4, 4'h0, 4'h6, 2'd0}, // R4 lowest empty line0
        {1'b1, 4'd6, 4'h0, 4'h6, 2'd0}, // R6 fill empty line0 -> [0,1,3,2]
        {1'b0, 4'd9, 4'h0, 4'hF, 2'd2}, // R9 update visible next cycle
        {1'b1, 4'd6, 4'hA, 4'hF, 2'd2}, // R6 multi-hit picks line1 -> [1,0,3,2]
        {1'b1, 4'd7, 4'h4, 4'hF, 2'd2}, // R7 hit oldest -> [2,1,0,3]
        {1'b0, 4'd5, 4'h0, 4'hF, 2'd3}, // R5 oldest now line3
        {1'b0, 4'd4, 4'h0, 4'h0, 2'd0}  // R4 all empty -> line0
    };

    task automatic check_victim(input int req, input logic [1:0] exp_idx, input string what);
        n_checks++;
        if (victim_idx !== exp_idx) begin
            n_fails++;
            $display("FAIL R%0d %s victim_idx actual %0d expected %0d", req, what, victim_idx, exp_idx);
        end
        n_checks++;
        if (victim_oh !== (4'b0001 << exp_idx)) begin
            n_fails++;
            $display("FAIL R2 %s victim_oh actual %b expected %b", what, victim_oh, 4'b0001 << exp_idx);
        end
    endtask

    initial begin
        #(200000 * 5);
        n_fails++;
        $display("FAIL R3 watchdog actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            upd_en    = VEC[v][14];
            hit_vec   = VEC[v][9:6];
            valid_vec = VEC[v][5:2];
            #1;
            check_victim(int'(VEC[v][13:10]), VEC[v][1:0], $sformatf("vector %0d", v));
        end

        // R1: touch line3 so ages become [3,2,1,0], then reset restores order.
        @(negedge clk);
        upd_en = 1'b1; hit_vec = 4'h8; valid_vec = 4'hF;
        @(negedge clk);
        upd_en = 1'b0; hit_vec = 4'h0;
        #1;
        check_victim(5, 2'd0, "pre-reset");
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check_victim(1, 2'd3, "after reset");

        // R8: single-line set always names line 0.
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            w1_upd   = k[0];
            w1_hit   = k[1:1];
            w1_valid = k[0:0];
            #1;
            n_checks++;
            if (w1_idx !== 1'b0 || w1_oh !== 1'b1) begin
                n_fails++;
                $display("FAIL R8 single-line idx/oh actual %0d/%b expected 0/1", w1_idx, w1_oh);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule